// File: doc/BRIEF.md
# Replayable FIFO with Half-Full Flag

This block is a single-clock first-in/first-out buffer of `DATA_W`-bit words (9 by default) with a power-of-two depth, normally 512 to 4096 words. The block sequences addresses itself with a write ring pointer and a read ring pointer, so the user supplies no address. Each pointer carries one wrap bit above its address bits. A write strobe stores `wr_data`. A read strobe pops the oldest word, and that word appears on `rd_data` one cycle later, qualified by `rd_valid`. The valid signal replaces a tri-stated data bus.

A rewind strobe moves the read ring pointer back to location zero and leaves the write pointer where it is. Everything written since reset can then be read out again, as long as no more than the full depth was written. The status flags come from a four-state fill-level machine.

The machine states are:
- `LVL_EMPTY`: nothing stored.
- `LVL_LOW`: 1 up to half the depth stored.
- `LVL_HIGH`: more than half the depth but not full.
- `LVL_FULL`: depth words stored.

The machine transitions are:
- **fill**: EMPTY to LOW on a write.
- **cross-up**: LOW to HIGH on a write that takes the occupancy above half.
- **top-out**: HIGH to FULL on a write that reaches the depth.
- **unfill**: FULL to HIGH on a read.
- **cross-down**: HIGH to LOW on a read that brings the occupancy to half or below.
- **drain**: LOW to EMPTY on the last read.
- **rewind**: from any state to the state that the recomputed occupancy gives.

In every other case the machine holds its state.

Top module: `fifo_rt`

## Requirements
- R1: While `rst_n` is low at a clock edge, both pointers go to location zero. In the cycle after release, `empty`=1, `full`=0, `half`=0 and `rd_valid`=0.
- R2: Words are read in the order they were written. A read accepted at edge N drives the word on `rd_data` with `rd_valid`=1 after edge N.
- R3: `full` rises after DEPTH accepted writes with no read. A write strobe while `full`=1 is dropped, and the stored words and flags are unchanged.
- R4: `empty`=1 exactly when the occupancy is zero. A read strobe while `empty`=1 is dropped: `rd_valid` stays 0 and the next write is the next word read.
- R5: `half`=1 exactly when the occupancy exceeds DEPTH/2. It is set by the write that passes DEPTH/2 and cleared by the read that brings the occupancy to DEPTH/2 or less.
- R6: A rewind with both strobes low moves the read pointer to location zero and leaves the write pointer alone. The occupancy becomes the number of words written since reset (at most DEPTH), and all flags, `half` included, follow the new occupancy.
- R7: A rewind strobe in a cycle where `wr_en` or `rd_en` is high has no effect. The read and write proceed as if the rewind strobe were low.
- R8: `rd_valid` is 1 only in the cycle after an accepted read. In every other cycle `rd_data` is 0.
- R9: A read and a write in the same cycle are both accepted when the FIFO is neither empty nor full. The occupancy and all three flags stay unchanged.
- R10: `empty` and `full` are never 1 together, and `full`=1 implies `half`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rewind | input | 1 | Replay strobe: read pointer back to location zero |
| rd_data | output | DATA_W | Word read, 0 when not valid |
| rd_valid | output | 1 | Output enable for rd_data |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| half | output | 1 | More than DEPTH/2 words stored |

## Verification
The bench compares against a queue model on every cycle under four kinds of stimulus:
- **Single-strobe streams**: fill to full and drain to empty. These separate the cross-up, top-out, unfill, cross-down and drain transitions, and catch an off-by-one at the half-depth threshold.
- **Strobes against flags**: writes against a full FIFO and reads against an empty one. These show whether a blocked strobe still moves a pointer.
- **Concurrent strobes**: both strobes in the same cycle mid-range. This tells a correct net-zero update apart from a level machine that follows only one of the strobes.
- **Rewinds**: a rewind after a partial fill with some reads, one that changes `half`, one after exactly DEPTH writes, and rewinds masked by an active strobe. These separate a correct read-pointer reset from one that also disturbs the write side, or that misreads the full-depth wrap case.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

    // Fill level of the buffer, ordered by occupancy
    typedef enum logic [1:0] {
        LVL_EMPTY = 2'd0,
        LVL_LOW   = 2'd1,
        LVL_HIGH  = 2'd2,
        LVL_FULL  = 2'd3
    } lvl_t;

endpackage

// File: rtl/fifo_rt_ptrs.sv
module fifo_rt_ptrs #(
    parameter int AW = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_go,
    input  logic        rd_go,
    input  logic        rt_go,
    output logic [AW:0] wptr,
    output logic [AW:0] rptr,
    output logic [AW:0] wptr_nx,
    output logic [AW:0] rptr_nx
);

    logic wr_off_zero;

    assign wr_off_zero = |wptr[AW-1:0];

    always_comb begin
        wptr_nx = wptr;
        rptr_nx = rptr;
        if (wr_go)
            wptr_nx = wptr + 1'b1;
        if (rt_go)
            // Location zero. The wrap bit is chosen so that the distance
            // equals the write count, DEPTH included.
            rptr_nx = {wptr[AW] & wr_off_zero, {AW{1'b0}}};
        else if (rd_go)
            rptr_nx = rptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            wptr <= wptr_nx;
            rptr <= rptr_nx;
        end
    end

endmodule

// File: rtl/fifo_rt_level.sv
module fifo_rt_level
    import fifo_rt_pkg::*;
#(
    parameter int AW    = 9,
    parameter int DEPTH = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_go,
    input  logic        rd_go,
    input  logic        rt_go,
    input  logic [AW:0] occ_nx,
    output logic        empty,
    output logic        full,
    output logic        half
);

    localparam logic [AW:0] HALF_V = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0] TOP_V  = (AW+1)'(DEPTH);

    lvl_t state, state_nx;
    logic wr_only, rd_only;

    assign wr_only = wr_go & ~rd_go;
    assign rd_only = rd_go & ~wr_go;

    function automatic lvl_t grade(input logic [AW:0] occ);
        if (occ == '0)         return LVL_EMPTY;
        else if (occ <= HALF_V) return LVL_LOW;
        else if (occ < TOP_V)   return LVL_HIGH;
        else                    return LVL_FULL;
    endfunction

    // Transition logic
    always_comb begin
        state_nx = state;
        unique case (state)
            LVL_EMPTY: begin
                if (rt_go)       state_nx = grade(occ_nx);   // rewind
                else if (wr_go)  state_nx = LVL_LOW;         // fill
            end
            LVL_LOW: begin
                if (rt_go)                          state_nx = grade(occ_nx);
                else if (wr_only && occ_nx > HALF_V) state_nx = LVL_HIGH;   // cross-up
                else if (rd_only && occ_nx == '0)    state_nx = LVL_EMPTY;  // drain
            end
            LVL_HIGH: begin
                if (rt_go)                            state_nx = grade(occ_nx);
                else if (wr_only && occ_nx == TOP_V)   state_nx = LVL_FULL;  // top-out
                else if (rd_only && occ_nx <= HALF_V)  state_nx = LVL_LOW;   // cross-down
            end
            LVL_FULL: begin
                if (rt_go)       state_nx = grade(occ_nx);
                else if (rd_go)  state_nx = LVL_HIGH;        // unfill
            end
            default: state_nx = LVL_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LVL_EMPTY;
        else        state <= state_nx;
    end

    // Outputs decoded from the state
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        half  = 1'b0;
        unique case (state)
            LVL_EMPTY: empty = 1'b1;
            LVL_LOW:   ;
            LVL_HIGH:  half = 1'b1;
            LVL_FULL: begin
                full = 1'b1;
                half = 1'b1;
            end
            default: empty = 1'b1;
        endcase
    end

endmodule

// File: rtl/fifo_rt_store.sv
module fifo_rt_store #(
    parameter int DATA_W = 9,
    parameter int AW     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_go,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    localparam int WORDS = 1 << AW;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_go)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_go;
            rdata  <= rd_go ? mem[raddr] : '0;
        end
    end

endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
    import fifo_rt_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rewind,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty,
    output logic              full,
    output logic              half
);

    localparam int AW = $clog2(DEPTH);

    logic        wr_go, rd_go, rt_go;
    logic [AW:0] wptr, rptr, wptr_nx, rptr_nx, occ_nx;

    assign wr_go  = wr_en & ~full;
    assign rd_go  = rd_en & ~empty;
    assign rt_go  = rewind & ~wr_en & ~rd_en;
    assign occ_nx = wptr_nx - rptr_nx;

    fifo_rt_ptrs #(.AW(AW)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .rt_go   (rt_go),
        .wptr    (wptr),
        .rptr    (rptr),
        .wptr_nx (wptr_nx),
        .rptr_nx (rptr_nx)
    );

    fifo_rt_level #(.AW(AW), .DEPTH(DEPTH)) u_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_go  (wr_go),
        .rd_go  (rd_go),
        .rt_go  (rt_go),
        .occ_nx (occ_nx),
        .empty  (empty),
        .full   (full),
        .half   (half)
    );

    fifo_rt_store #(.DATA_W(DATA_W), .AW(AW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_go  (wr_go),
        .waddr  (wptr[AW-1:0]),
        .wdata  (wr_data),
        .rd_go  (rd_go),
        .raddr  (rptr[AW-1:0]),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_en,
    input logic rd_valid,
    input logic empty,
    input logic full,
    input logic half
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (empty && !full && !half && !rd_valid));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> full);

    // R4
    read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> !rd_valid);

    // R8
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && !empty));

    // R9
    rw_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && wr_en && rd_en) |=> ($stable(empty) && $stable(full) && $stable(half)));

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R10
    full_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half);

endmodule

bind fifo_rt fifo_rt_chk u_chk (.*);

// File: tb/fifo_rt_test.sv
module fifo_rt_test;

    localparam int DW    = 9;
    localparam int DEPTH = 512;
    localparam int HALFD = DEPTH / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          rewind = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid, empty, full, half;

    always #10 clk = ~clk;

    fifo_rt #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rewind(rewind), .rd_data(rd_data),
        .rd_valid(rd_valid), .empty(empty), .full(full), .half(half)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] hist[$];

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(string tag, bit w, logic [DW-1:0] d, bit r, bit t);
        bit acc_w, acc_r, rt_ok;
        logic [DW-1:0] ed;
        wr_en = w; wr_data = d; rd_en = r; rewind = t;
        @(posedge clk);
        acc_w = w && (q.size() < DEPTH);
        acc_r = r && (q.size() > 0);
        rt_ok = t && !w && !r;
        ed = acc_r ? q[0] : '0;
        if (acc_r) void'(q.pop_front());
        if (rt_ok) q = hist;
        if (acc_w) begin
            q.push_back(d);
            hist.push_back(d);
        end
        @(negedge clk);
        chk(tag, "rd_valid", rd_valid, acc_r);
        chk(tag, "rd_data",  rd_data, ed);
        chk(tag, "empty",    empty, q.size() == 0);
        chk(tag, "full",     full, q.size() == DEPTH);
        chk(tag, "half",     half, q.size() > HALFD);
        wr_en = 0; rd_en = 0; rewind = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0; rd_en = 0; rewind = 0;
        repeat (2) @(posedge clk);
        q.delete();
        hist.delete();
        @(negedge clk);
        rst_n = 1;
        chk("R1", "empty", empty, 1);
        chk("R1", "full", full, 0);
        chk("R1", "half", half, 0);
        chk("R1", "rd_valid", rd_valid, 0);
    endtask

    function automatic logic [DW-1:0] rnd();
        return DW'($urandom_range(0, (1 << DW) - 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R4: reads against an empty FIFO are dropped
        step("R4", 0, '0, 1, 0);
        step("R4", 0, '0, 1, 0);
        step("R4", 1, 9'd77, 0, 0);
        step("R4", 0, '0, 1, 0);

        // R2: order, with a concurrent pair
        for (int i = 0; i < 3; i++) step("R2", 1, rnd(), 0, 0);
        step("R2", 1, rnd(), 1, 0);
        for (int i = 0; i < 4; i++) step("R2", 0, '0, 1, 0);

        // R5 / R3: fill to full across the half threshold
        for (int i = 0; i < DEPTH; i++)
            step((i < HALFD + 2) ? "R5" : "R3", 1, rnd(), 0, 0);
        chk("R10", "half while full", half, 1);
        chk("R10", "empty while full", empty, 0);
        for (int i = 0; i < 3; i++) step("R3", 1, rnd(), 0, 0);
        step("R3", 1, rnd(), 1, 0);

        // R9: concurrent strobes mid-range
        for (int i = 0; i < 10; i++) step("R5", 0, '0, 1, 0);
        for (int i = 0; i < 20; i++) step("R9", 1, rnd(), 1, 0);

        // R5: drain to empty across the half threshold
        while (q.size() > 0) step("R5", 0, '0, 1, 0);
        step("R4", 0, '0, 1, 0);

        // R6 / R7: rewind after a partial fill
        do_reset();
        for (int i = 0; i < 10; i++) step("R6", 1, rnd(), 0, 0);
        for (int i = 0; i < 6; i++)  step("R6", 0, '0, 1, 0);
        step("R7", 0, '0, 1, 1);
        step("R7", 1, rnd(), 0, 1);
        step("R6", 0, '0, 0, 1);
        chk("R6", "words after rewind", q.size(), 11);
        for (int i = 0; i < 11; i++) step("R6", 0, '0, 1, 0);
        for (int i = 0; i < 2; i++)  step("R6", 1, rnd(), 0, 0);
        for (int i = 0; i < 3; i++)  step("R6", 0, '0, 1, 0);

        // R6 / R5: rewind raises half again
        do_reset();
        for (int i = 0; i < HALFD + 1; i++) step("R5", 1, rnd(), 0, 0);
        step("R5", 0, '0, 1, 0);
        step("R5", 0, '0, 1, 0);
        step("R6", 0, '0, 0, 1);
        chk("R6", "half after rewind", half, 1);

        // R6: exactly DEPTH writes, drain, rewind gives full again
        do_reset();
        for (int i = 0; i < DEPTH; i++) step("R3", 1, rnd(), 0, 0);
        while (q.size() > 0) step("R6", 0, '0, 1, 0);
        step("R6", 0, '0, 0, 1);
        chk("R6", "full after rewind", full, 1);
        for (int i = 0; i < 5; i++) step("R6", 0, '0, 1, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule